// File: doc/BRIEF.md
# Compare Output Pin Unit

This block owns the single output-compare level bit of one timer channel and decides what a shared I/O pin shows. The timer core feeds it three things: a one-cycle compare-match pulse, a one-cycle pulse when the counter sits at BOTTOM, and a flag that says whether the timer runs a non-PWM mode or fast PWM. Software-side registers supply a 2-bit output-action field, a one-cycle force strobe, the pin's general port data bit, its direction bit, and a direct write of the level bit.

In the non-PWM modes a compare match, or a force strobe, sets, clears or toggles the level bit. In fast PWM a match drives the level to one value and BOTTOM drives it back to the other, which gives a non-inverted or an inverted waveform. The action applied at BOTTOM is the one that was in force at the most recent match, so a change of the field settles in at the next match. While the field is zero the pin shows the port data bit, and the level bit can be loaded directly so that a known level is already present when the override is switched on. All control and status pins are plain level or pulse signals with no handshake. Reset is synchronous and active low.

Top module: `cmp_out_unit`

## Requirements
- R1: After reset the level bit `oc_state` is 0 and the remembered action is "none", so a BOTTOM pulse before the first match leaves the level unchanged.
- R2: When `com_mode` is nonzero `pin_out` equals `oc_state`; when `com_mode` is 0 `pin_out` equals `port_data`. The mux is combinational.
- R3: `pin_oe` always equals `port_dir`, whatever `com_mode` holds.
- R4: With `com_mode` = 0 a compare match or force strobe leaves `oc_state` unchanged.
- R5: With `pwm_mode` = 0, a compare match changes `oc_state` at the next clock edge: `com_mode` 1 toggles it, 2 drives it to 0, 3 drives it to 1.
- R6: With `pwm_mode` = 0, `force_strobe` applies the same action as a match at the next edge without any match; a strobe and a match in the same cycle apply the action once.
- R7: With `pwm_mode` = 1, `force_strobe` has no effect on `oc_state`.
- R8: With `pwm_mode` = 1, a compare match with `com_mode` 2 drives `oc_state` to 0 and with `com_mode` 3 drives it to 1; values 0 and 1 leave it unchanged.
- R9: With `pwm_mode` = 1, a BOTTOM pulse without a match sets `oc_state` to 1 when the remembered action is 2 and to 0 when it is 3; when a match and BOTTOM coincide the match action wins.
- R10: The remembered action is loaded from `com_mode` at every compare match (and at a force strobe in non-PWM mode); a BOTTOM pulse uses the remembered value, not a newly written `com_mode`.
- R11: `state_wr_en` loads `state_wr_data` into `oc_state` at the next edge only when `com_mode` is 0, taking priority over a BOTTOM action; with `com_mode` nonzero the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_mode | input | 1 | 0 = non-PWM mode class, 1 = fast PWM |
| cmp_match | input | 1 | One-cycle compare-match pulse from the comparator |
| at_bottom | input | 1 | One-cycle pulse when the counter is at BOTTOM |
| com_mode | input | 2 | Output action field (0 none, 1 toggle, 2 low/non-inverted, 3 high/inverted) |
| force_strobe | input | 1 | One-cycle force request |
| state_wr_en | input | 1 | Direct write enable for the level bit |
| state_wr_data | input | 1 | Value for the direct write |
| port_data | input | 1 | General port data bit for the pin |
| port_dir | input | 1 | Pin direction bit, 1 = output |
| oc_state | output | 1 | Current compare output level bit |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench sweeps every combination of the ten input bits in three orders, so each action meets each prior level and each remembered action, and compares the level and both pin outputs against a model built from the requirements. It aims at a force strobe in fast PWM (a design that honours it would move the waveform), a strobe coinciding with a match (a double toggle would leave the level unchanged), and a BOTTOM pulse after the field has been rewritten without an intervening match (a design reading the live field would set instead of clear). It also checks a direct write while the override is on (a leaky write would glitch the pin) and a match landing on BOTTOM (giving BOTTOM priority would produce a spurious full-on cycle).

// File: rtl/ocu_pkg.sv
`timescale 1ns/1ps
package ocu_pkg;
  localparam int unsigned COM_W = 2;

  typedef enum logic [COM_W-1:0] {
    COM_NONE   = 2'd0,
    COM_FLIP   = 2'd1,
    COM_LOW    = 2'd2,
    COM_HIGH   = 2'd3
  } com_e;
endpackage

// File: rtl/ocu_action.sv
`timescale 1ns/1ps
module ocu_action
  import ocu_pkg::*;
(
  input  logic             pwm_mode,
  input  logic [COM_W-1:0] com_mode,
  input  logic [COM_W-1:0] held_mode,
  input  logic             cur_level,
  input  logic             cmp_match,
  input  logic             force_strobe,
  input  logic             at_bottom,
  input  logic             wr_en,
  input  logic             wr_data,
  output logic             nxt_level,
  output logic [COM_W-1:0] nxt_held
);
  com_e live_c, held_c;
  logic trig_np;

  assign live_c  = com_e'(com_mode);
  assign held_c  = com_e'(held_mode);
  assign trig_np = cmp_match | force_strobe;

  always_comb begin
    nxt_level = cur_level;
    nxt_held  = held_mode;
    if (!pwm_mode) begin
      if (trig_np) begin
        nxt_held = com_mode;
        case (live_c)
          COM_FLIP: nxt_level = ~cur_level;
          COM_LOW:  nxt_level = 1'b0;
          COM_HIGH: nxt_level = 1'b1;
          default:  nxt_level = cur_level;
        endcase
      end
    end else begin
      if (cmp_match) begin
        nxt_held = com_mode;
        case (live_c)
          COM_LOW:  nxt_level = 1'b0;
          COM_HIGH: nxt_level = 1'b1;
          default:  nxt_level = cur_level;
        endcase
      end else if (at_bottom) begin
        case (held_c)
          COM_LOW:  nxt_level = 1'b1;
          COM_HIGH: nxt_level = 1'b0;
          default:  nxt_level = cur_level;
        endcase
      end
    end
    if (wr_en && (live_c == COM_NONE)) begin
      nxt_level = wr_data;
    end
  end
endmodule

// File: rtl/ocu_state.sv
`timescale 1ns/1ps
module ocu_state
  import ocu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nxt_level,
  input  logic [COM_W-1:0] nxt_held,
  output logic             level_q,
  output logic [COM_W-1:0] held_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      held_q  <= COM_NONE;
    end else begin
      level_q <= nxt_level;
      held_q  <= nxt_held;
    end
  end
endmodule

// File: rtl/ocu_pin_mux.sv
`timescale 1ns/1ps
module ocu_pin_mux
  import ocu_pkg::*;
(
  input  logic [COM_W-1:0] com_mode,
  input  logic             level,
  input  logic             port_data,
  input  logic             port_dir,
  output logic             pin_out,
  output logic             pin_oe
);
  logic override_on;

  assign override_on = |com_mode;
  assign pin_out     = override_on ? level : port_data;
  assign pin_oe      = port_dir;
endmodule

// File: rtl/cmp_out_unit.sv
`timescale 1ns/1ps
module cmp_out_unit
  import ocu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_mode,
  input  logic             cmp_match,
  input  logic             at_bottom,
  input  logic [COM_W-1:0] com_mode,
  input  logic             force_strobe,
  input  logic             state_wr_en,
  input  logic             state_wr_data,
  input  logic             port_data,
  input  logic             port_dir,
  output logic             oc_state,
  output logic             pin_out,
  output logic             pin_oe
);
  logic             nxt_level;
  logic [COM_W-1:0] nxt_held;
  logic [COM_W-1:0] held_q;

  ocu_action u_action (
    .pwm_mode     (pwm_mode),
    .com_mode     (com_mode),
    .held_mode    (held_q),
    .cur_level    (oc_state),
    .cmp_match    (cmp_match),
    .force_strobe (force_strobe),
    .at_bottom    (at_bottom),
    .wr_en        (state_wr_en),
    .wr_data      (state_wr_data),
    .nxt_level    (nxt_level),
    .nxt_held     (nxt_held)
  );

  ocu_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt_level (nxt_level),
    .nxt_held  (nxt_held),
    .level_q   (oc_state),
    .held_q    (held_q)
  );

  ocu_pin_mux u_mux (
    .com_mode  (com_mode),
    .level     (oc_state),
    .port_data (port_data),
    .port_dir  (port_dir),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );
endmodule

// File: rtl/cmp_out_unit_chk.sv
`timescale 1ns/1ps
module cmp_out_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwm_mode,
  input logic       cmp_match,
  input logic       at_bottom,
  input logic [1:0] com_mode,
  input logic       force_strobe,
  input logic       state_wr_en,
  input logic       oc_state
);
  assert_none_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (com_mode == 2'd0 && !state_wr_en && !(pwm_mode && at_bottom)) |=> $stable(oc_state));

  assert_np_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_mode && (cmp_match || force_strobe) && com_mode == 2'd1) |=> (oc_state != $past(oc_state)));

  assert_np_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_mode && (cmp_match || force_strobe) && com_mode == 2'd2) |=> !oc_state);

  assert_np_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_mode && (cmp_match || force_strobe) && com_mode == 2'd3) |=> oc_state);

  assert_pwm_force_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !cmp_match && !at_bottom && !(state_wr_en && com_mode == 2'd0)) |=> $stable(oc_state));

  assert_pwm_match_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && cmp_match && com_mode == 2'd2) |=> !oc_state);

  assert_pwm_match_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && cmp_match && com_mode == 2'd3) |=> oc_state);

  assert_write_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (com_mode != 2'd0 && !cmp_match && !force_strobe && !at_bottom) |=> $stable(oc_state));
endmodule

bind cmp_out_unit cmp_out_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwm_mode     (pwm_mode),
  .cmp_match    (cmp_match),
  .at_bottom    (at_bottom),
  .com_mode     (com_mode),
  .force_strobe (force_strobe),
  .state_wr_en  (state_wr_en),
  .oc_state     (oc_state)
);

// File: tb/tb_cmp_out_unit.sv
`timescale 1ns/1ps
module tb_cmp_out_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_mode = 1'b0, cmp_match = 1'b0, at_bottom = 1'b0;
  logic [1:0] com_mode = 2'd0;
  logic       force_strobe = 1'b0, state_wr_en = 1'b0, state_wr_data = 1'b0;
  logic       port_data = 1'b0, port_dir = 1'b0;
  logic       oc_state, pin_out, pin_oe;

  int n_checks = 0;
  int n_fail   = 0;
  logic       m_level = 1'b0;
  logic [1:0] m_held  = 2'd0;

  always #2.5 clk = ~clk;

  cmp_out_unit dut (
    .clk(clk), .rst_n(rst_n), .pwm_mode(pwm_mode), .cmp_match(cmp_match),
    .at_bottom(at_bottom), .com_mode(com_mode), .force_strobe(force_strobe),
    .state_wr_en(state_wr_en), .state_wr_data(state_wr_data),
    .port_data(port_data), .port_dir(port_dir),
    .oc_state(oc_state), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // v[0] pwm, v[2:1] com, v[3] match, v[4] force, v[5] bottom,
  // v[6] wr_en, v[7] wr_data, v[8] port_data, v[9] port_dir
  function automatic logic [9:0] mk(input logic p, input logic [1:0] c, input logic m,
                                    input logic f, input logic b, input logic we,
                                    input logic wd, input logic pd, input logic pr);
    return {pr, pd, wd, we, b, f, m, c, p};
  endfunction

  task automatic apply(input logic [9:0] v);
    logic       es;
    logic [1:0] eh;
    string      tag;
    @(negedge clk);
    pwm_mode = v[0]; com_mode = v[2:1]; cmp_match = v[3]; force_strobe = v[4];
    at_bottom = v[5]; state_wr_en = v[6]; state_wr_data = v[7];
    port_data = v[8]; port_dir = v[9];
    es = m_level; eh = m_held; tag = "R4";
    if (!v[0]) begin
      if (v[3] || v[4]) begin
        eh = v[2:1];
        tag = v[4] ? "R6" : "R5";
        case (v[2:1])
          2'd1: es = ~m_level;
          2'd2: es = 1'b0;
          2'd3: es = 1'b1;
          default: tag = "R4";
        endcase
      end
    end else begin
      tag = "R7";
      if (v[3]) begin
        eh = v[2:1]; tag = "R8";
        if (v[2:1] == 2'd2) es = 1'b0;
        if (v[2:1] == 2'd3) es = 1'b1;
      end else if (v[5]) begin
        tag = "R10";
        if (m_held == 2'd2) es = 1'b1;
        if (m_held == 2'd3) es = 1'b0;
      end
    end
    if (v[6]) begin
      if (v[2:1] == 2'd0) es = v[7];
      tag = "R11";
    end
    @(posedge clk);
    #1;
    check(tag, "oc_state", oc_state, es);
    check("R2", "pin_out", pin_out, (v[2:1] != 2'd0) ? es : v[8]);
    check("R3", "pin_oe", pin_oe, v[9]);
    m_level = es; m_held = eh;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    com_mode = 2'd3; cmp_match = 1'b1; pwm_mode = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "oc_state after reset", oc_state, 1'b0);
    @(negedge clk);
    rst_n = 1'b1; cmp_match = 1'b0; com_mode = 2'd0;
    m_level = 1'b0; m_held = 2'd0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1: bottom before any match does nothing, even in PWM with live field 2
    apply(mk(1, 2'd2, 0, 0, 1, 0, 0, 1, 1));
    check("R1", "no action before first match", oc_state, 1'b0);
    // R10: remembered action, not live field
    apply(mk(1, 2'd3, 1, 0, 0, 0, 0, 0, 1)); // match -> 1, held 3
    apply(mk(1, 2'd2, 0, 0, 1, 0, 0, 0, 1)); // bottom uses 3 -> 0
    check("R10", "bottom after rewrite", oc_state, 1'b0);
    apply(mk(1, 2'd2, 1, 0, 0, 0, 0, 0, 1)); // match -> 0, held 2
    apply(mk(1, 2'd2, 0, 0, 1, 0, 0, 0, 1)); // bottom -> 1
    check("R9", "bottom non-inverted sets", oc_state, 1'b1);
    apply(mk(1, 2'd2, 1, 0, 1, 0, 0, 0, 1)); // match wins over bottom -> 0
    check("R9", "match beats bottom", oc_state, 1'b0);
    // R6: force and match together toggle once
    apply(mk(0, 2'd1, 1, 1, 0, 0, 0, 0, 0));
    check("R6", "single toggle", oc_state, 1'b1);
    // R11: direct write then override keeps the level
    apply(mk(0, 2'd0, 0, 0, 0, 1, 0, 1, 1));
    apply(mk(0, 2'd2, 0, 0, 0, 1, 1, 1, 1));
    check("R11", "write ignored with override on", pin_out, 1'b0);
    // exhaustive sweeps in three orders
    for (int i = 0; i < 1024; i++) apply(10'(i));
    for (int i = 0; i < 1024; i++) apply(10'((i * 389 + 7) % 1024));
    for (int i = 0; i < 1024; i++) apply(10'(1023 - i));
    do_reset();
    apply(mk(0, 2'd3, 0, 1, 0, 0, 0, 0, 1));
    check("R6", "force sets without match", oc_state, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule